// File: doc/BRIEF.md
# Byte-Command I2C Bus Master

This block is a memory-mapped I2C bus master that software steers one byte at a time. Software places a byte in the data register and then writes a command byte. A single command can ask for a START condition, one byte written or read, and a STOP after that byte's acknowledge slot, in any useful combination. On reads the command also picks the level the master drives in the acknowledge slot. The bus pins are open-drain: the block only ever pulls SCL or SDA low, and it reads the wired line levels back.

A 16-bit prescaler divides the system clock into ticks at five times the SCL rate. Each bit period therefore takes five ticks. SDA moves only while SCL is low, except for the deliberate edges that form START and STOP. A status register reports transfer in progress, the last acknowledge level, bus busy, lost arbitration and a pending interrupt. The interrupt output stays high until software acknowledges it through the command register.

Top module: `i2cm_top`

## Requirements
- R1: Byte registers sit at these offsets: 0x00 prescale bits 7:0, 0x04 prescale bits 15:8, 0x08 control (bit 7 core enable, bit 6 interrupt enable), 0x0C data (a write sets the transmit byte, a read returns the last received byte), 0x10 command on write and status on read (status bit 7 last acknowledge level, bit 6 bus busy, bit 5 arbitration lost, bit 1 transfer in progress, bit 0 interrupt pending). Every register reads 0 after reset and no line is pulled low.
- R2: With prescale value P, one SCL period lasts 5*(P+1) system clocks.
- R3: Command bits are 7 START, 6 STOP, 5 READ, 4 WRITE, 3 NACK, 0 IACK. A command write with any of bits 7..4 set is accepted only while the core is enabled and no transfer is in progress, and it sets the in-progress flag. Otherwise those bits are ignored.
- R4: A WRITE shifts the transmit byte out MSB first, releases SDA in the ninth slot and stores the sampled level as the acknowledge status (1 = not acknowledged).
- R5: A READ shifts eight bits in MSB first into the data register. In the ninth slot the master pulls SDA low when bit 3 is 0 and releases it when bit 3 is 1. The sampled slot level is stored as the acknowledge status.
- R6: START comes before the byte of the same command and STOP comes after that byte's acknowledge slot. Bus busy sets when a START is seen on the lines and clears when a STOP is seen.
- R7: If SDA reads low during a write data bit in which the master releases it, arbitration-lost sets, the in-progress flag clears, and both lines are released until the next accepted command, which clears arbitration-lost.
- R8: When interrupts are enabled, the end of a command or a lost arbitration sets interrupt-pending, and the interrupt output follows it. IACK clears it in the same write that may also start a new command. If a set and a clear fall in the same cycle, the set wins.
- R9: While SCL is released high, the master changes its SDA drive only to form START (drive low) or STOP (release).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr |
| scl_in | input | 1 | Wired SCL line level |
| sda_in | input | 1 | Wired SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt request, high while interrupt-pending is set |

## Verification
Two functions can land in one cycle. An IACK can clear interrupt-pending in the same write that launches the next byte, and a byte can complete in the same cycle that tries to set that flag. The bench provokes the first case by sending IACK and WRITE as one command byte. In the cycle after the write it expects the interrupt output low and the in-progress flag high, and it expects the interrupt to return only once that byte has finished. A command written while a byte is in flight must leave neither a second transfer nor an extra byte at the bus model.

// File: rtl/i2cm_pkg.sv
// Shared register offsets, bit positions and types for the I2C byte master.
// Assumes 8-bit registers on a byte-offset register bus.
package i2cm_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_PRE_LO = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_PRE_HI = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_DATA   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CMD    = 5'h10;

    localparam int CTL_EN   = 7;
    localparam int CTL_IE   = 6;
    localparam int CB_START = 7;
    localparam int CB_STOP  = 6;
    localparam int CB_READ  = 5;
    localparam int CB_WRITE = 4;
    localparam int CB_NACK  = 3;
    localparam int CB_IACK  = 0;

    typedef struct packed {
        logic start;
        logic stop;
        logic rd;
        logic wr;
        logic nack;
    } cmd_t;

    typedef enum logic [1:0] {SQ_IDLE, SQ_START, SQ_DATA, SQ_STOP} seq_e;
endpackage

// File: rtl/i2cm_tick.sv
// Prescaler: pulses tick once every (limit+1) clocks while enabled.
// Assumes limit is changed only while the core is disabled.
module i2cm_tick #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;

    assign tick = en && (cnt == limit);

    // Free-running divider, held at zero while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2cm_bitctl.sv
// Bit-level sequencer: runs START, one data byte with its acknowledge slot,
// and STOP, five prescaler ticks per bit. Outputs are registered pull-low
// enables. Assumes go is pulsed only while the sequencer is idle.
module i2cm_bitctl
    import i2cm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go,
    input  cmd_t              cmd_in,
    input  logic [DATA_W-1:0] tx_in,
    input  logic              sda_in,
    output logic              scl_dl,
    output logic              sda_dl,
    output logic              done,
    output logic              lost,
    output logic              ack_valid,
    output logic              ack_seen,
    output logic              rx_load,
    output logic [DATA_W-1:0] rx_byte,
    output logic              cond_phase
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(DATA_W);

    seq_e              st;
    logic [2:0]        ph;
    logic [CNT_W-1:0]  bit_idx;
    cmd_t              cmd_q;
    logic [DATA_W-1:0] sh;
    logic              bit_out;

    // Level the master wants on SDA in the current bit slot (1 = release)
    always_comb begin
        if (bit_idx == ACK_IDX)
            bit_out = cmd_q.rd ? cmd_q.nack : 1'b1;
        else
            bit_out = cmd_q.rd ? 1'b1 : sh[DATA_W-1];
    end

    assign rx_byte    = sh;
    assign cond_phase = (st == SQ_START) || (st == SQ_STOP);

    // Sequencer: phase stepping, line drive, sampling and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SQ_IDLE; ph <= '0; bit_idx <= '0; cmd_q <= '0; sh <= '0;
            scl_dl <= 1'b0; sda_dl <= 1'b0; done <= 1'b0; lost <= 1'b0;
            ack_valid <= 1'b0; ack_seen <= 1'b0; rx_load <= 1'b0;
        end else begin
            done <= 1'b0; lost <= 1'b0; ack_valid <= 1'b0; rx_load <= 1'b0;
            if (go) begin
                cmd_q   <= cmd_in;
                sh      <= tx_in;
                ph      <= '0;
                bit_idx <= '0;
                if (cmd_in.start)               st <= SQ_START;
                else if (cmd_in.rd || cmd_in.wr) st <= SQ_DATA;
                else                            st <= SQ_STOP;
            end else if (tick && st != SQ_IDLE) begin
                ph <= (ph == 3'd4) ? 3'd0 : ph + 3'd1;
                case (st)
                    SQ_START: case (ph)
                        3'd0: sda_dl <= 1'b0;
                        3'd1: scl_dl <= 1'b0;
                        3'd2: sda_dl <= 1'b1;
                        3'd4: begin
                            scl_dl <= 1'b1;
                            if (cmd_q.rd || cmd_q.wr) st <= SQ_DATA;
                            else begin st <= SQ_IDLE; done <= 1'b1; end
                        end
                        default: ;
                    endcase
                    SQ_DATA: case (ph)
                        3'd0: sda_dl <= !bit_out;
                        3'd2: scl_dl <= 1'b0;
                        3'd3: begin
                            if (bit_idx == ACK_IDX) begin
                                ack_seen  <= sda_in;
                                ack_valid <= 1'b1;
                            end else if (!cmd_q.rd && bit_out && !sda_in) begin
                                lost   <= 1'b1;
                                st     <= SQ_IDLE;
                                ph     <= '0;
                                scl_dl <= 1'b0;
                                sda_dl <= 1'b0;
                            end else begin
                                sh <= {sh[DATA_W-2:0], sda_in};
                            end
                        end
                        3'd4: begin
                            scl_dl <= 1'b1;
                            if (bit_idx == ACK_IDX) begin
                                bit_idx <= '0;
                                rx_load <= cmd_q.rd;
                                if (cmd_q.stop) st <= SQ_STOP;
                                else begin st <= SQ_IDLE; done <= 1'b1; end
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                    SQ_STOP: case (ph)
                        3'd0: sda_dl <= 1'b1;
                        3'd1: scl_dl <= 1'b0;
                        3'd3: sda_dl <= 1'b0;
                        3'd4: begin st <= SQ_IDLE; done <= 1'b1; end
                        default: ;
                    endcase
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cm_top.sv
// I2C byte-command master: register file, command acceptance, status and
// interrupt, bus busy detection; instantiates prescaler and bit sequencer.
// Assumes an external pull-up on both lines and no clock stretching.
module i2cm_top
    import i2cm_pkg::*;
#(
    parameter int PRE_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic              irq
);
    logic [PRE_W-1:0]  pre_q;
    logic              en_q, ie_q;
    logic [BYTE_W-1:0] tx_q, rx_q;
    logic              tip_q, ip_q, al_q, rxack_q, busy_q;
    logic              scl_s, sda_s;
    logic              tick, done, lost, ack_valid, ack_seen, rx_load, cond_phase;
    logic [BYTE_W-1:0] rx_byte;
    logic              cmd_wr, accept, start_det, stop_det;
    cmd_t              cmd_in;

    assign cmd_wr = bus_wr && (bus_addr == OFS_CMD);
    assign accept = cmd_wr && en_q && !tip_q && (|bus_wdata[CB_START:CB_WRITE]);
    assign cmd_in = '{start: bus_wdata[CB_START], stop: bus_wdata[CB_STOP],
                      rd: bus_wdata[CB_READ], wr: bus_wdata[CB_WRITE],
                      nack: bus_wdata[CB_NACK]};
    assign start_det = scl_in && scl_s && sda_s && !sda_in;
    assign stop_det  = scl_in && scl_s && !sda_s && sda_in;
    assign irq       = ip_q;

    // Software-written configuration and transmit byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0; en_q <= 1'b0; ie_q <= 1'b0; tx_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_PRE_LO: pre_q[BYTE_W-1:0]     <= bus_wdata;
                OFS_PRE_HI: pre_q[PRE_W-1:BYTE_W] <= bus_wdata;
                OFS_CTRL: begin
                    en_q <= bus_wdata[CTL_EN];
                    ie_q <= bus_wdata[CTL_IE];
                end
                OFS_DATA: tx_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Status flags, received byte and line sampling for busy detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tip_q <= 1'b0; ip_q <= 1'b0; al_q <= 1'b0; rxack_q <= 1'b0;
            busy_q <= 1'b0; rx_q <= '0; scl_s <= 1'b1; sda_s <= 1'b1;
        end else begin
            scl_s <= scl_in;
            sda_s <= sda_in;
            if (accept)             tip_q <= 1'b1;
            else if (done || lost)  tip_q <= 1'b0;
            if ((done || lost) && ie_q)            ip_q <= 1'b1;
            else if (cmd_wr && bus_wdata[CB_IACK]) ip_q <= 1'b0;
            if (accept)    al_q <= 1'b0;
            else if (lost) al_q <= 1'b1;
            if (ack_valid) rxack_q <= ack_seen;
            if (rx_load)   rx_q <= rx_byte;
            if (start_det)     busy_q <= 1'b1;
            else if (stop_det) busy_q <= 1'b0;
        end
    end

    // Register read multiplexer
    always_comb begin
        case (bus_addr)
            OFS_PRE_LO: bus_rdata = pre_q[BYTE_W-1:0];
            OFS_PRE_HI: bus_rdata = pre_q[PRE_W-1:BYTE_W];
            OFS_CTRL:   bus_rdata = {en_q, ie_q, 6'b0};
            OFS_DATA:   bus_rdata = rx_q;
            OFS_CMD:    bus_rdata = {rxack_q, busy_q, al_q, 3'b0, tip_q, ip_q};
            default:    bus_rdata = '0;
        endcase
    end

    i2cm_tick #(.CNT_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(en_q), .limit(pre_q), .tick(tick)
    );

    i2cm_bitctl #(.DATA_W(BYTE_W)) u_bit (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go(accept), .cmd_in(cmd_in),
        .tx_in(tx_q), .sda_in(sda_in), .scl_dl(scl_drive_low),
        .sda_dl(sda_drive_low), .done(done), .lost(lost),
        .ack_valid(ack_valid), .ack_seen(ack_seen), .rx_load(rx_load),
        .rx_byte(rx_byte), .cond_phase(cond_phase)
    );
endmodule

// File: rtl/i2cm_chk.sv
// Protocol checker for i2cm_top, attached by bind below.
// Observes ports plus the status flags and the sequencer's condition phase.
module i2cm_chk
    import i2cm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic              tip,
    input logic              ip,
    input logic              al,
    input logic              scl_dl,
    input logic              sda_dl,
    input logic              cond_phase
);
    assert_tip_from_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tip) |-> $past(bus_wr && bus_addr == OFS_CMD));

    assert_iack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CMD && bus_wdata[CB_IACK] && !tip) |=> !ip);

    assert_ip_on_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ip) |-> ($past(tip) && !tip));

    assert_lost_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (al && !tip) |-> (!scl_dl && !sda_dl));

    assert_sda_high_scl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_dl && $past(!scl_dl) && (sda_dl != $past(sda_dl))) |-> cond_phase);
endmodule

bind i2cm_top i2cm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .tip(tip_q), .ip(ip_q), .al(al_q),
    .scl_dl(scl_drive_low), .sda_dl(sda_drive_low), .cond_phase(cond_phase)
);

// File: tb/sim_i2cm_top.sv
`timescale 1ns/1ps
// Bench for i2cm_top: open-drain bus with a behavioural target at address 0x2A.
module sim_i2cm_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       scl_drive_low, sda_drive_low, irq;
    logic       slv_dl = 1'b0;
    logic       hold_low = 1'b0;
    wire        scl_line = !scl_drive_low;
    wire        sda_line = !(sda_drive_low || slv_dl || hold_low);

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    i2cm_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_in(scl_line),
        .sda_in(sda_line), .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low), .irq(irq)
    );

    // Behavioural target: responds to address 0x2A, stores written bytes,
    // returns an incrementing byte starting at 0xC5 on reads.
    localparam logic [6:0] SLV = 7'h2A;
    logic [7:0] got [16];
    int         ngot = 0;
    logic [7:0] rd_val = 8'hC5;
    logic [7:0] s_sh = '0;
    logic       s_act = 0, s_addr = 0, s_sel = 0, s_rd = 0, s_mack = 0;
    logic       p_scl = 1, p_sda = 1;
    int         s_bit = 0;
    int         n_start = 0, n_stop = 0;

    always @(scl_line or sda_line) begin
        if (scl_line && p_scl && (sda_line != p_sda)) begin
            if (!sda_line) begin s_act = 1; s_addr = 1; s_bit = 0; slv_dl = 0; end
            else begin s_act = 0; slv_dl = 0; end
        end else if (scl_line && !p_scl && s_act) begin
            if (s_bit < 8) s_sh = {s_sh[6:0], sda_line};
            else s_mack = sda_line;
            s_bit++;
        end else if (!scl_line && p_scl && s_act) begin
            if (s_bit == 8) begin
                if (s_addr) begin
                    s_sel = (s_sh[7:1] == SLV); s_rd = s_sh[0] & s_sel; slv_dl = s_sel;
                end else if (!s_rd && s_sel) begin
                    if (ngot < 16) got[ngot] = s_sh;
                    ngot++; slv_dl = 1;
                end else slv_dl = 0;
            end else if (s_bit == 9) begin
                s_bit = 0;
                if (s_rd && !s_addr) rd_val++;
                slv_dl = s_rd && (s_addr || !s_mack) && !rd_val[7];
                s_addr = 0;
            end else if (s_rd && !s_addr && s_bit < 8) slv_dl = !rd_val[7 - s_bit];
            else slv_dl = 0;
        end
        p_scl = scl_line;
        p_sda = sda_line;
    end

    // Counts master SDA drive edges while SCL is high (R9)
    always @(posedge sda_drive_low) if (scl_line) n_start++;
    always @(negedge sda_drive_low) if (scl_line) n_stop++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic br(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 4000; i++) begin
            br(5'h10, s);
            if (!s[1]) break;
        end
    endtask

    // Vector: cmd, tx, expected rxack, expected busy, check rx, expected rx
    localparam int NV = 8;
    localparam logic [26:0] VEC [NV] = '{
        {8'h90, 8'h54, 1'b0, 1'b1, 1'b0, 8'h00},
        {8'h10, 8'h3C, 1'b0, 1'b1, 1'b0, 8'h00},
        {8'h50, 8'h81, 1'b0, 1'b0, 1'b0, 8'h00},
        {8'h90, 8'h55, 1'b0, 1'b1, 1'b0, 8'h00},
        {8'h20, 8'h00, 1'b0, 1'b1, 1'b1, 8'hC5},
        {8'h68, 8'h00, 1'b1, 1'b0, 1'b1, 8'hC6},
        {8'h90, 8'h20, 1'b1, 1'b1, 1'b0, 8'h00},
        {8'h40, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00}
    };

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [7:0] s;
        time t1, t2;
        int  g0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        br(5'h10, s); chk("R1 status reset", s, 8'h00);
        br(5'h08, s); chk("R1 control reset", s, 8'h00);
        br(5'h00, s); chk("R1 prescale reset", s, 8'h00);
        chk("R1 lines released", {scl_drive_low, sda_drive_low, irq}, 3'b000);

        bw(5'h00, 8'h03);
        bw(5'h04, 8'h00);
        bw(5'h08, 8'h80);
        br(5'h08, s); chk("R1 control readback", s, 8'h80);

        // R4 R5 R6: vector walk
        for (int v = 0; v < NV; v++) begin
            bw(5'h0C, VEC[v][18:11]);
            bw(5'h10, VEC[v][26:19]);
            wait_idle();
            br(5'h10, s);
            chk($sformatf("R4 R5 R6 vector %0d status", v), s,
                {VEC[v][10], VEC[v][9], 6'b0});
            if (VEC[v][8]) begin
                br(5'h0C, s);
                chk($sformatf("R5 vector %0d rx", v), s, VEC[v][7:0]);
            end
        end
        chk("R4 target byte count", ngot, 2);
        chk("R4 target byte 0", got[0], 8'h3C);
        chk("R4 target byte 1", got[1], 8'h81);
        chk("R9 start edges", n_start, 3);
        chk("R9 stop edges", n_stop, 3);

        // R2: SCL period with prescale 7
        bw(5'h08, 8'h00);
        bw(5'h00, 8'h07);
        bw(5'h08, 8'h80);
        bw(5'h0C, 8'h54);
        bw(5'h10, 8'h90);
        @(posedge scl_line); t1 = $time;
        @(posedge scl_line); t2 = $time;
        chk("R2 scl period ns", 32'(t2 - t1), 32'd320);
        wait_idle();
        bw(5'h10, 8'h40);
        wait_idle();
        bw(5'h08, 8'h00);
        bw(5'h00, 8'h03);

        // R3: command ignored while disabled
        bw(5'h0C, 8'h54);
        bw(5'h10, 8'h90);
        repeat (60) @(negedge clk);
        br(5'h10, s); chk("R3 disabled ignores command", s & 8'h02, 8'h00);
        chk("R3 disabled lines", {scl_drive_low, sda_drive_low}, 2'b00);

        // R8 R3: interrupt, IACK with command, command during transfer
        bw(5'h08, 8'hC0);
        bw(5'h0C, 8'h54);
        bw(5'h10, 8'h90);
        wait_idle();
        chk("R8 irq after byte", irq, 1'b1);
        br(5'h10, s); chk("R8 pending flag", s & 8'h03, 8'h01);
        g0 = ngot;
        bw(5'h0C, 8'h66);
        bw(5'h10, 8'h11);
        chk("R8 IACK with WRITE clears irq", irq, 1'b0);
        br(5'h10, s); chk("R3 WRITE accepted with IACK", s & 8'h03, 8'h02);
        bw(5'h10, 8'h20);
        wait_idle();
        repeat (60) @(negedge clk);
        br(5'h10, s); chk("R3 command during transfer ignored", s & 8'h03, 8'h01);
        chk("R3 one byte only", ngot - g0, 1);
        chk("R4 written byte", got[g0], 8'h66);
        bw(5'h10, 8'h41);
        wait_idle();
        br(5'h10, s); chk("R6 stop clears busy", s & 8'h43, 8'h01);
        bw(5'h10, 8'h01);
        chk("R8 IACK alone clears irq", irq, 1'b0);

        // R7: arbitration lost
        bw(5'h0C, 8'h54);
        bw(5'h10, 8'h90);
        wait_idle();
        bw(5'h10, 8'h01);
        hold_low = 1;
        bw(5'h0C, 8'hFF);
        bw(5'h10, 8'h10);
        wait_idle();
        br(5'h10, s); chk("R7 lost flag and pending", s & 8'h23, 8'h21);
        chk("R7 lines released", {scl_drive_low, sda_drive_low}, 2'b00);
        chk("R8 irq on lost", irq, 1'b1);
        hold_low = 0;
        repeat (20) @(negedge clk);
        br(5'h10, s); chk("R6 busy clears on release", s & 8'h40, 8'h00);
        bw(5'h10, 8'h01);
        bw(5'h0C, 8'h54);
        bw(5'h10, 8'h90);
        br(5'h10, s); chk("R7 new command clears lost", s & 8'h20, 8'h00);
        wait_idle();
        bw(5'h10, 8'h40);
        wait_idle();

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule